// File: doc/BRIEF.md
# E1 Timeslot-16 Signalling Multiframe Formatter

This block builds the timeslot-16 octet that an E1 framer places in each frame of a 16-frame signalling multiframe. It stores a 4-bit channel-associated signalling code for each of the 30 voice channels. Software or a control engine loads these codes through a single-cycle write port. The framer announces each new frame with a strobe and the frame number. One clock later, the block presents the octet for that frame.

Frame 0 carries the multiframe alignment pattern and the remote loss-of-multiframe alarm. Frame k, for k from 1 to 15, carries the codes of two channels: channel k and channel k+15. Writes go into a pending bank. The pending bank is copied into the active bank only when the framer signals frame 0. Because of this, the codes sent within one multiframe all come from a single snapshot.

Top module: `ts16_cas_fmt`

## Requirements
- R1: After reset, `ts16_byte` is 8'hFF and every channel's active and pending code equals `IDLE_CODE` (default 4'hD). Frame k then shows {IDLE_CODE, IDLE_CODE}.
- R2: A strobe with `frm_idx` = 0 produces an octet whose upper nibble (bits 7:4, first-transmitted bit in bit 7) is 4'b0000.
- R3: In the frame-0 octet, bit 2 equals `mf_alarm` as sampled on the strobe cycle, and bits 3, 1 and 0 are 1. With no alarm the octet is 8'h0B; with the alarm it is 8'h0F.
- R4: A strobe with `frm_idx` = k (1 to 15) produces an octet whose bits 7:4 are the active code of channel k and whose bits 3:0 are the active code of channel k+15.
- R5: A write with `wr_chan` = 0 or greater than 30 changes no channel's code.
- R6: A write takes effect only at the next frame-0 strobe. Until then, frames continue to carry the previous code.
- R7: A write issued in the same cycle as a frame-0 strobe is not part of the multiframe that strobe starts. It appears from the following frame-0 strobe onward.
- R8: Between strobes, `ts16_byte` holds its value, even if `mf_alarm` or the write port change.
- R9: Several writes to one channel before a boundary leave the last written code in effect.
- R10: `ts16_byte` changes on the first rising edge at which `frm_start` is sampled high, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | One-cycle strobe: a new frame begins |
| frm_idx | input | 4 | Frame number within the multiframe, valid with the strobe |
| mf_alarm | input | 1 | Loss-of-multiframe alarm to report in frame 0 |
| wr_en | input | 1 | Write strobe for one signalling code |
| wr_chan | input | 5 | Voice channel number, 1 to 30 |
| wr_code | input | 4 | Signalling code to store |
| ts16_byte | output | 8 | Timeslot-16 octet, bit 7 sent first |

## Verification
A code stored in the wrong channel, or a wrong pairing of k with k+15, shows up as a wrong nibble in the octet of the affected frame. This appears one clock after that frame's strobe, so at most one multiframe passes before it is visible. A bank copy taken at the wrong time shows in two ways. A fresh code can appear inside the multiframe in which it was written. Or a code can fail to appear right after frame 0. Both are caught by sampling frames just before and just after a boundary. A corrupted frame-0 layout is exposed on every multiframe start, with the alarm both low and high.

// File: rtl/ts16_pkg.sv
package ts16_pkg;
  localparam int CODE_W = 4;
  localparam int OCT_W  = 2 * CODE_W;

  typedef logic [CODE_W-1:0] cas_code_t;
  typedef logic [OCT_W-1:0]  ts_oct_t;

  // Alignment nibble sent in bits 7:4 of frame 0
  localparam cas_code_t MF_ALIGN = 4'b0000;

  // Frame-0 octet: alignment, spare 1, alarm, spare 1, spare 1
  function automatic ts_oct_t mf_head_oct(input logic alarm);
    return {MF_ALIGN, 1'b1, alarm, 2'b11};
  endfunction

  // Channel-pair octet: lower-numbered channel goes out first
  function automatic ts_oct_t pair_oct(input cas_code_t first, input cas_code_t second);
    return {first, second};
  endfunction

  function automatic ts_oct_t frame_oct(input logic is_head, input logic alarm,
                                        input cas_code_t first, input cas_code_t second);
    return is_head ? mf_head_oct(alarm) : pair_oct(first, second);
  endfunction
endpackage

// File: rtl/ts16_cas_bank.sv
module ts16_cas_bank
  import ts16_pkg::*;
#(
  parameter int        N_CHAN    = 30,
  parameter cas_code_t IDLE_CODE = 4'hD,
  localparam int       CH_W      = $clog2(N_CHAN + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [CH_W-1:0]               wr_chan,
  input  cas_code_t                     wr_code,
  input  logic                          load,
  output logic [N_CHAN-1:0][CODE_W-1:0] pend_codes,
  output logic [N_CHAN-1:0][CODE_W-1:0] act_codes
);
  // One storage cell pair per channel; entry 0 holds channel 1
  for (genvar g = 0; g < N_CHAN; g++) begin : g_cell
    logic hit;
    assign hit = wr_en && (wr_chan == CH_W'(g + 1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_codes[g] <= IDLE_CODE;
        act_codes[g]  <= IDLE_CODE;
      end else begin
        if (hit)  pend_codes[g] <= wr_code;
        if (load) act_codes[g]  <= pend_codes[g];
      end
    end
  end
endmodule

// File: rtl/ts16_pair_sel.sv
module ts16_pair_sel
  import ts16_pkg::*;
#(
  parameter int  N_CHAN = 30,
  localparam int HALF   = N_CHAN / 2,
  localparam int FIDX_W = $clog2(HALF + 1)
) (
  input  logic [FIDX_W-1:0]             frm_idx,
  input  logic [N_CHAN-1:0][CODE_W-1:0] codes,
  output cas_code_t                     first,
  output cas_code_t                     second
);
  always_comb begin
    first  = '0;
    second = '0;
    for (int k = 0; k < HALF; k++) begin
      if (frm_idx == FIDX_W'(k + 1)) begin
        first  = codes[k];
        second = codes[k + HALF];
      end
    end
  end
endmodule

// File: rtl/ts16_cas_fmt.sv
module ts16_cas_fmt
  import ts16_pkg::*;
#(
  parameter int        N_CHAN    = 30,
  parameter cas_code_t IDLE_CODE = 4'hD,
  localparam int       HALF      = N_CHAN / 2,
  localparam int       FIDX_W    = $clog2(HALF + 1),
  localparam int       CH_W      = $clog2(N_CHAN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_start,
  input  logic [FIDX_W-1:0] frm_idx,
  input  logic              mf_alarm,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [CODE_W-1:0] wr_code,
  output logic [OCT_W-1:0]  ts16_byte
);
  // Named internal events for the checker
  logic                          head_frame;
  logic                          bank_load;
  logic [N_CHAN-1:0][CODE_W-1:0] pend_codes;
  logic [N_CHAN-1:0][CODE_W-1:0] act_codes;
  cas_code_t                     sel_first;
  cas_code_t                     sel_second;
  ts_oct_t                       oct_q;

  assign head_frame = (frm_idx == '0);
  assign bank_load  = frm_start && head_frame;

  ts16_cas_bank #(.N_CHAN(N_CHAN), .IDLE_CODE(IDLE_CODE)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_chan    (wr_chan),
    .wr_code    (wr_code),
    .load       (bank_load),
    .pend_codes (pend_codes),
    .act_codes  (act_codes)
  );

  // The frame-0 octet needs no codes, so using the pre-load bank is safe
  ts16_pair_sel #(.N_CHAN(N_CHAN)) u_sel (
    .frm_idx (frm_idx),
    .codes   (act_codes),
    .first   (sel_first),
    .second  (sel_second)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         oct_q <= '1;
    else if (frm_start) oct_q <= frame_oct(head_frame, mf_alarm, sel_first, sel_second);
  end

  assign ts16_byte = oct_q;
endmodule

// File: rtl/ts16_cas_fmt_chk.sv
module ts16_cas_fmt_chk #(
  parameter int  N_CHAN = 30,
  localparam int HALF   = N_CHAN / 2,
  localparam int FIDX_W = $clog2(HALF + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    frm_start,
  input logic [FIDX_W-1:0]       frm_idx,
  input logic                    mf_alarm,
  input logic [7:0]              ts16_byte,
  input logic                    bank_load,
  input logic [N_CHAN-1:0][3:0]  pend_codes,
  input logic [N_CHAN-1:0][3:0]  act_codes
);
  p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && frm_idx == '0) |=> ts16_byte[7:4] == 4'b0000);

  p_head_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && frm_idx == '0) |=>
      (ts16_byte[3] && ts16_byte[1] && ts16_byte[0] && ts16_byte[2] == $past(mf_alarm)));

  p_pair_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && frm_idx == FIDX_W'(1)) |=>
      ts16_byte == {act_codes[0], act_codes[HALF]});

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_start |=> $stable(ts16_byte));

  p_bank_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_load |=> $stable(act_codes));

  p_bank_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bank_load |=> act_codes == $past(pend_codes));
endmodule

bind ts16_cas_fmt ts16_cas_fmt_chk #(.N_CHAN(N_CHAN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frm_start  (frm_start),
  .frm_idx    (frm_idx),
  .mf_alarm   (mf_alarm),
  .ts16_byte  (ts16_byte),
  .bank_load  (bank_load),
  .pend_codes (pend_codes),
  .act_codes  (act_codes)
);

// File: tb/test_ts16_cas_fmt.sv
module test_ts16_cas_fmt;
  logic       clk = 1'b0;
  logic       rst_n, frm_start, mf_alarm, wr_en;
  logic [3:0] frm_idx, wr_code;
  logic [4:0] wr_chan;
  logic [7:0] ts16_byte;

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0] m_pend [1:30];
  logic [3:0] m_act  [1:30];

  always #10 clk = ~clk;

  ts16_cas_fmt i_ts16_cas_fmt (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_idx(frm_idx),
    .mf_alarm(mf_alarm), .wr_en(wr_en), .wr_chan(wr_chan), .wr_code(wr_code),
    .ts16_byte(ts16_byte)
  );

  // Bench model of the octet, written from the requirements
  function automatic logic [7:0] want(input int idx);
    if (idx == 0) return 8'h0B | (mf_alarm ? 8'h04 : 8'h00);
    return {m_act[idx], m_act[idx + 15]};
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic strobe_check(input string req, input int idx);
    logic [7:0] e;
    @(negedge clk);
    frm_start = 1'b1; frm_idx = 4'(idx);
    if (idx == 0) for (int c = 1; c <= 30; c++) m_act[c] = m_pend[c];
    e = want(idx);
    @(negedge clk);
    frm_start = 1'b0;
    check(req, ts16_byte, e);
  endtask

  task automatic run_mf(input string req);
    for (int f = 0; f < 16; f++) strobe_check(req, f);
  endtask

  task automatic write(input int ch, input logic [3:0] code);
    @(negedge clk);
    wr_en = 1'b1; wr_chan = 5'(ch); wr_code = code;
    @(negedge clk);
    wr_en = 1'b0;
    if (ch >= 1 && ch <= 30) m_pend[ch] = code;
  endtask

  task automatic t_reset;
    check("R1 reset octet", ts16_byte, 8'hFF);
    run_mf("R1 idle codes / R2 / R4");
    mf_alarm = 1'b1;
    strobe_check("R3 alarm set", 0);
    mf_alarm = 1'b0;
    strobe_check("R3 alarm clear", 0);
  endtask

  task automatic t_defer;
    write(1, 4'h3); write(16, 4'h5);
    strobe_check("R6 old code before boundary", 1);
    check("R6 frame1 still idle", ts16_byte, 8'hDD);
    strobe_check("R6 boundary", 0);
    strobe_check("R6 new code after boundary", 1);
    check("R4 pairing ch1/ch16", ts16_byte, 8'h35);
  endtask

  task automatic t_all;
    for (int c = 1; c <= 30; c++) write(c, 4'((c * 7) % 16));
    strobe_check("R4 boundary", 0);
    for (int f = 1; f < 16; f++) strobe_check("R4 all pairs", f);
    strobe_check("R10 out of order frame", 9);
    strobe_check("R10 repeated frame", 2);
  endtask

  task automatic t_illegal;
    write(0, 4'h0); write(31, 4'h0);
    run_mf("R5 illegal channels ignored");
    strobe_check("R5 frame15 unchanged", 15);
  endtask

  task automatic t_collide;
    logic [7:0] e;
    @(negedge clk);
    frm_start = 1'b1; frm_idx = 4'd0;
    wr_en = 1'b1; wr_chan = 5'd4; wr_code = 4'hA;
    for (int c = 1; c <= 30; c++) m_act[c] = m_pend[c];
    e = want(0);
    @(negedge clk);
    frm_start = 1'b0; wr_en = 1'b0;
    m_pend[4] = 4'hA;
    check("R7 head octet", ts16_byte, e);
    strobe_check("R7 write not in this multiframe", 4);
    strobe_check("R7 next boundary", 0);
    strobe_check("R7 write now visible", 4);
    check("R7 ch4 code", ts16_byte[7:4], 4'hA);
  endtask

  task automatic t_last_wins;
    write(30, 4'h1); write(30, 4'h2); write(30, 4'h6);
    strobe_check("R9 boundary", 0);
    strobe_check("R9 last write wins", 15);
    check("R9 ch30 code", {4'h0, ts16_byte[3:0]}, 8'h06);
  endtask

  task automatic t_hold;
    logic [7:0] e;
    strobe_check("R8 setup", 0);
    e = ts16_byte;
    mf_alarm = 1'b1;
    write(7, 4'h9);
    repeat (3) @(negedge clk);
    check("R8 held without strobe", ts16_byte, e);
    mf_alarm = 1'b0;
    @(negedge clk);
    frm_start = 1'b1; frm_idx = 4'd3;
    @(posedge clk);
    #1;
    check("R10 one-edge latency", ts16_byte, want(3));
    @(negedge clk);
    frm_start = 1'b0;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frm_start = 1'b0; frm_idx = '0; mf_alarm = 1'b0;
    wr_en = 1'b0; wr_chan = '0; wr_code = '0;
    for (int c = 1; c <= 30; c++) begin m_pend[c] = 4'hD; m_act[c] = 4'hD; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_defer;
    t_all;
    t_illegal;
    t_collide;
    t_last_wins;
    t_hold;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule